// File: doc/BRIEF.md
# Home Directory with Sticky Ownership

This block is the home directory for a small set of memory blocks in a multiprocessor whose private caches use a MOESI protocol. For every block it records whether one core holds it as owner, which core that is, and a full bit vector of sharing cores. It also holds the backing data for each block. Cores send requests on a request channel, and the directory answers them. It may forward a request to the owner. It may send invalidations to sharers. It may also supply data from its own storage. Each request that needs coherence work stays open until the requester sends a final acknowledge or negative acknowledge on a separate response channel.

The block supports transactional caches that evict data they have read or written. When a core writes back a modified block during a transaction, memory takes the new data, but the core stays on record as owner. Later requests keep reaching that core, so it can report a conflict. The directory does not clear this ownership at commit. It clears it only when the core answers a forwarded request with a clean-up message, which means it holds no live transactional claim. A core that writes back an Owned or Exclusive block stays on record as a sharer, so a later exclusive request still invalidates it.

Top module: `dir_sticky_home`

## Requirements
- R1: Request codes are GETS=0, GETX=1, PUTX=2, transactional writeback=3, shared writeback=4. Response codes are CLEAN=1, ACK=2, NACK=3. Outgoing codes are forwarded GETS=0, forwarded GETX=1, INV=2, DATA=3, writeback acknowledge=4. After reset no message goes out, req_ready is high, every block has no owner and no sharers, and all stored data is zero.
- R2: A GETS or GETX to a block with no owner gets DATA from storage, addressed to the requester. A GETS to a block with neither owner nor sharers, once ACKed, leaves the requester as sole owner.
- R3: A GETS or GETX to a block owned by another core is forwarded to that owner and carries the requester's index in out_src. After the ACK of a forwarded GETS, the owner keeps ownership and the requester becomes a sharer.
- R4: A GETX first sends its forward or DATA message. It then sends one INV, one per cycle in ascending core order, to each sharer other than the requester and the owner. After the ACK, the requester is the only holder.
- R5: A PUTX is answered at once with a writeback acknowledge to its sender and leaves the block state as it was.
- R6: A transactional writeback from the owner stores its data and keeps the writer as sticky owner, so later GETS and GETX requests are still forwarded to it.
- R7: A CLEAN from the sticky owner of an open transaction sends DATA holding the stored value to the requester. After the ACK, the requester is the sole owner and the sticky record is gone.
- R8: A NACK from the requester closes the open transaction and changes no state, so a retry produces the same forward.
- R9: A shared writeback from the owner stores its data, removes the ownership, and adds the writer as a sharer. A later GETX then gets the stored data and invalidates the writer.
- R10: A sharer that drops a Shared block without telling the directory stays in the sharer vector and receives an INV on a later GETX.
- R11: While a transaction waits for its final ACK or NACK, no other request is served and no message goes out for one. Waiting requests are then served in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request queue has room |
| req_type | input | 3 | Request code |
| req_src | input | CW | Requesting core |
| req_blk | input | BW | Block index |
| req_data | input | DW | Writeback data |
| rsp_valid | input | 1 | Response present |
| rsp_type | input | 2 | Response code |
| rsp_src | input | CW | Responding core |
| rsp_blk | input | BW | Block of the response |
| out_valid | output | 1 | Outgoing message present |
| out_type | output | 3 | Outgoing code |
| out_dst | output | CW | Destination core |
| out_src | output | CW | Core the message acts for |
| out_blk | output | BW | Block index |
| out_data | output | DW | Data for DATA messages, else zero |

## Verification
The assertions assume that a final ACK or NACK arrives only while a transaction is open, and only after its last invalidation has gone out. They also assume that only the owner of the block sends a CLEAN. The bench keeps to these rules by draining all outgoing messages before it sends any response. It names the real owner as the sender of each CLEAN. It sends each final response from the core that opened the transaction.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [2:0] {
        RQ_GETS = 3'd0,
        RQ_GETX = 3'd1,
        RQ_PUTX = 3'd2,
        RQ_WBTX = 3'd3,
        RQ_WBSH = 3'd4
    } req_op_e;

    typedef enum logic [1:0] {
        RS_NONE  = 2'd0,
        RS_CLEAN = 2'd1,
        RS_ACK   = 2'd2,
        RS_NACK  = 2'd3
    } rsp_op_e;

    typedef enum logic [2:0] {
        OM_FWDS  = 3'd0,
        OM_FWDX  = 3'd1,
        OM_INV   = 3'd2,
        OM_DATA  = 3'd3,
        OM_WBACK = 3'd4
    } out_op_e;
endpackage

// File: rtl/dir_req_fifo.sv
// dir_req_fifo: in-order request queue.
// Assumes DEPTH is a power of two; push is ignored when full.
module dir_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rp_q];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (!do_push && do_pop) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= din;
    end
endmodule

// File: rtl/dir_table.sv
// dir_table: per-block ownership record and backing data.
// One index serves both the read and the write port; reads are combinational.
module dir_table #(
    parameter int NCORES = 4,
    parameter int NBLK   = 8,
    parameter int DW     = 32,
    parameter int CW     = 2,
    parameter int BW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BW-1:0]     blk,
    output logic              rd_own_vld,
    output logic [CW-1:0]     rd_owner,
    output logic [NCORES-1:0] rd_sharers,
    output logic              rd_sticky,
    output logic [DW-1:0]     rd_data,
    input  logic              ent_we,
    input  logic              ent_own_vld,
    input  logic [CW-1:0]     ent_owner,
    input  logic [NCORES-1:0] ent_sharers,
    input  logic              ent_sticky,
    input  logic              mem_we,
    input  logic [DW-1:0]     mem_wdata
);
    logic              own_vld_q [NBLK];
    logic [CW-1:0]     owner_q   [NBLK];
    logic [NCORES-1:0] sharers_q [NBLK];
    logic              sticky_q  [NBLK];
    logic [DW-1:0]     data_q    [NBLK];

    assign rd_own_vld = own_vld_q[blk];
    assign rd_owner   = owner_q[blk];
    assign rd_sharers = sharers_q[blk];
    assign rd_sticky  = sticky_q[blk];
    assign rd_data    = data_q[blk];

    // Record and data update; everything is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                own_vld_q[b] <= 1'b0;
                owner_q[b]   <= '0;
                sharers_q[b] <= '0;
                sticky_q[b]  <= 1'b0;
                data_q[b]    <= '0;
            end
        end else begin
            if (ent_we) begin
                own_vld_q[blk] <= ent_own_vld;
                owner_q[blk]   <= ent_owner;
                sharers_q[blk] <= ent_sharers;
                sticky_q[blk]  <= ent_sticky;
            end
            if (mem_we) data_q[blk] <= mem_wdata;
        end
    end
endmodule

// File: rtl/dir_ctrl.sv
// dir_ctrl: serves one coherence transaction at a time.
// Assumes final ACK/NACK comes from the requester after its last INV,
// and CLEAN comes only from the recorded sticky owner.
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int DW     = 32,
    parameter int CW     = 2,
    parameter int BW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    output logic              q_pop,
    input  logic [2:0]        hd_type,
    input  logic [CW-1:0]     hd_src,
    input  logic [BW-1:0]     hd_blk,
    input  logic [DW-1:0]     hd_data,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_type,
    input  logic [CW-1:0]     rsp_src,
    input  logic [BW-1:0]     rsp_blk,
    output logic [BW-1:0]     tb_blk,
    input  logic              rd_own_vld,
    input  logic [CW-1:0]     rd_owner,
    input  logic [NCORES-1:0] rd_sharers,
    input  logic              rd_sticky,
    input  logic [DW-1:0]     rd_data,
    output logic              ent_we,
    output logic              ent_own_vld,
    output logic [CW-1:0]     ent_owner,
    output logic [NCORES-1:0] ent_sharers,
    output logic              ent_sticky,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              busy,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [CW-1:0]     out_dst,
    output logic [CW-1:0]     out_src,
    output logic [BW-1:0]     out_blk,
    output logic [DW-1:0]     out_data
);
    typedef enum logic [1:0] {C_IDLE, C_INV, C_WAIT} cst_e;

    function automatic logic [NCORES-1:0] bit_of(input logic [CW-1:0] idx);
        return NCORES'(1) << idx;
    endfunction

    cst_e              cst_q, cst_d;
    logic              getx_q, getx_d, fwd_q, fwd_d, clean_q, clean_d, due_q, due_d;
    logic [CW-1:0]     treq_q, treq_d;
    logic [BW-1:0]     tblk_q, tblk_d;
    logic [NCORES-1:0] inv_q, inv_d;
    logic [CW-1:0]     inv_idx;
    logic              o_vld_d;
    logic [2:0]        o_type_d;
    logic [CW-1:0]     o_dst_d, o_src_d;
    logic [BW-1:0]     o_blk_d;
    logic [DW-1:0]     o_data_d;
    logic              clean_hit, fin, is_fwd, excl;

    assign busy     = (cst_q != C_IDLE);
    assign tb_blk   = busy ? tblk_q : hd_blk;
    assign mem_wdata = hd_data;

    // Lowest pending invalidation target.
    always_comb begin
        inv_idx = '0;
        for (int c = NCORES-1; c >= 0; c--) begin
            if (inv_q[c]) inv_idx = CW'(c);
        end
    end

    // Response qualification against the open transaction.
    always_comb begin
        clean_hit = busy && rsp_valid && (rsp_op_e'(rsp_type) == RS_CLEAN) && (rsp_blk == tblk_q)
                    && fwd_q && rd_sticky && (rsp_src == rd_owner);
        fin = (cst_q == C_WAIT) && rsp_valid && (rsp_blk == tblk_q) && (rsp_src == treq_q)
              && ((rsp_op_e'(rsp_type) == RS_ACK) || (rsp_op_e'(rsp_type) == RS_NACK));
        is_fwd = rd_own_vld && (rd_owner != hd_src);
        excl = clean_q || (!rd_own_vld && (rd_sharers == '0)) || (rd_own_vld && rd_owner == treq_q);
    end

    // Next-state, table update and outgoing message selection.
    always_comb begin
        q_pop = 1'b0;
        ent_we = 1'b0;
        ent_own_vld = rd_own_vld;
        ent_owner = rd_owner;
        ent_sharers = rd_sharers;
        ent_sticky = rd_sticky;
        mem_we = 1'b0;
        o_vld_d = 1'b0;
        o_type_d = OM_DATA;
        o_dst_d = '0;
        o_src_d = '0;
        o_blk_d = tb_blk;
        o_data_d = '0;
        cst_d = cst_q;
        getx_d = getx_q;
        fwd_d = fwd_q;
        clean_d = clean_q;
        due_d = due_q;
        treq_d = treq_q;
        tblk_d = tblk_q;
        inv_d = inv_q;
        if (cst_q == C_IDLE) begin
            if (!q_empty) begin
                q_pop = 1'b1;
                case (req_op_e'(hd_type))
                    RQ_PUTX: begin
                        o_vld_d = 1'b1;
                        o_type_d = OM_WBACK;
                        o_dst_d = hd_src;
                        o_src_d = hd_src;
                    end
                    RQ_WBTX: begin
                        mem_we = 1'b1;
                        if (rd_own_vld && rd_owner == hd_src) begin
                            ent_we = 1'b1;
                            ent_sticky = 1'b1;
                        end
                    end
                    RQ_WBSH: begin
                        mem_we = 1'b1;
                        if (rd_own_vld && rd_owner == hd_src) begin
                            ent_we = 1'b1;
                            ent_own_vld = 1'b0;
                            ent_sticky = 1'b0;
                            ent_sharers = rd_sharers | bit_of(hd_src);
                        end
                    end
                    RQ_GETS, RQ_GETX: begin
                        o_vld_d = 1'b1;
                        o_src_d = hd_src;
                        if (is_fwd) begin
                            o_type_d = (req_op_e'(hd_type) == RQ_GETX) ? OM_FWDX : OM_FWDS;
                            o_dst_d = rd_owner;
                        end else begin
                            o_type_d = OM_DATA;
                            o_dst_d = hd_src;
                            o_data_d = rd_data;
                        end
                        getx_d = (req_op_e'(hd_type) == RQ_GETX);
                        fwd_d = is_fwd;
                        clean_d = 1'b0;
                        due_d = 1'b0;
                        treq_d = hd_src;
                        tblk_d = hd_blk;
                        inv_d = getx_d ? (rd_sharers & ~bit_of(hd_src) &
                                          ~(is_fwd ? bit_of(rd_owner) : '0)) : '0;
                        cst_d = (inv_d != '0) ? C_INV : C_WAIT;
                    end
                    default: ;
                endcase
            end
        end else begin
            if (due_q) begin
                o_vld_d = 1'b1;
                o_type_d = OM_DATA;
                o_dst_d = treq_q;
                o_src_d = treq_q;
                o_data_d = rd_data;
                due_d = 1'b0;
            end else if (cst_q == C_INV) begin
                o_vld_d = 1'b1;
                o_type_d = OM_INV;
                o_dst_d = inv_idx;
                o_src_d = treq_q;
                inv_d = inv_q & ~bit_of(inv_idx);
                if (inv_d == '0) cst_d = C_WAIT;
            end
            if (clean_hit) begin
                due_d = 1'b1;
                clean_d = 1'b1;
            end
            if (fin) begin
                cst_d = C_IDLE;
                due_d = 1'b0;
                if (rsp_op_e'(rsp_type) == RS_ACK) begin
                    ent_we = 1'b1;
                    if (getx_q || excl) begin
                        ent_own_vld = 1'b1;
                        ent_owner = treq_q;
                        ent_sharers = '0;
                        ent_sticky = 1'b0;
                    end else begin
                        ent_sharers = rd_sharers | bit_of(treq_q);
                    end
                end
            end
        end
    end

    // Transaction and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst_q <= C_IDLE;
            getx_q <= 1'b0;
            fwd_q <= 1'b0;
            clean_q <= 1'b0;
            due_q <= 1'b0;
            treq_q <= '0;
            tblk_q <= '0;
            inv_q <= '0;
            out_valid <= 1'b0;
            out_type <= '0;
            out_dst <= '0;
            out_src <= '0;
            out_blk <= '0;
            out_data <= '0;
        end else begin
            cst_q <= cst_d;
            getx_q <= getx_d;
            fwd_q <= fwd_d;
            clean_q <= clean_d;
            due_q <= due_d;
            treq_q <= treq_d;
            tblk_q <= tblk_d;
            inv_q <= inv_d;
            out_valid <= o_vld_d;
            out_type <= o_type_d;
            out_dst <= o_dst_d;
            out_src <= o_src_d;
            out_blk <= o_blk_d;
            out_data <= o_data_d;
        end
    end
endmodule

// File: rtl/dir_sticky_home.sv
// dir_sticky_home: home directory top. Requests are queued in arrival
// order; responses bypass the queue and go straight to the controller.
module dir_sticky_home #(
    parameter int NCORES = 4,
    parameter int NBLK   = 8,
    parameter int DW     = 32,
    parameter int QDEPTH = 4,
    localparam int CW    = $clog2(NCORES),
    localparam int BW    = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_type,
    input  logic [CW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_type,
    input  logic [CW-1:0] rsp_src,
    input  logic [BW-1:0] rsp_blk,
    output logic          out_valid,
    output logic [2:0]    out_type,
    output logic [CW-1:0] out_dst,
    output logic [CW-1:0] out_src,
    output logic [BW-1:0] out_blk,
    output logic [DW-1:0] out_data
);
    localparam int QW = 3 + CW + BW + DW;

    logic              q_full, q_empty, q_pop;
    logic [QW-1:0]     q_dout;
    logic [2:0]        hd_type;
    logic [CW-1:0]     hd_src;
    logic [BW-1:0]     hd_blk;
    logic [DW-1:0]     hd_data;
    logic [BW-1:0]     tb_blk;
    logic              rd_own_vld, rd_sticky, ent_we, ent_own_vld, ent_sticky, mem_we;
    logic [CW-1:0]     rd_owner, ent_owner;
    logic [NCORES-1:0] rd_sharers, ent_sharers;
    logic [DW-1:0]     rd_data, mem_wdata;
    logic              ctrl_busy, tbl_we;

    assign req_ready = !q_full;
    assign {hd_type, hd_src, hd_blk, hd_data} = q_dout;
    assign tbl_we = ent_we;

    dir_req_fifo #(.W(QW), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid), .din({req_type, req_src, req_blk, req_data}),
        .full(q_full), .pop(q_pop), .dout(q_dout), .empty(q_empty)
    );

    dir_table #(.NCORES(NCORES), .NBLK(NBLK), .DW(DW), .CW(CW), .BW(BW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .blk(tb_blk),
        .rd_own_vld(rd_own_vld), .rd_owner(rd_owner), .rd_sharers(rd_sharers),
        .rd_sticky(rd_sticky), .rd_data(rd_data),
        .ent_we(ent_we), .ent_own_vld(ent_own_vld), .ent_owner(ent_owner),
        .ent_sharers(ent_sharers), .ent_sticky(ent_sticky),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    dir_ctrl #(.NCORES(NCORES), .DW(DW), .CW(CW), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .q_pop(q_pop),
        .hd_type(hd_type), .hd_src(hd_src), .hd_blk(hd_blk), .hd_data(hd_data),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_src(rsp_src), .rsp_blk(rsp_blk),
        .tb_blk(tb_blk),
        .rd_own_vld(rd_own_vld), .rd_owner(rd_owner), .rd_sharers(rd_sharers),
        .rd_sticky(rd_sticky), .rd_data(rd_data),
        .ent_we(ent_we), .ent_own_vld(ent_own_vld), .ent_owner(ent_owner),
        .ent_sharers(ent_sharers), .ent_sticky(ent_sticky),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .busy(ctrl_busy),
        .out_valid(out_valid), .out_type(out_type), .out_dst(out_dst),
        .out_src(out_src), .out_blk(out_blk), .out_data(out_data)
    );
endmodule

// File: rtl/dir_sticky_home_chk.sv
// dir_sticky_home_chk: protocol properties of the directory, bound to the top.
module dir_sticky_home_chk #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rsp_valid,
    input logic [1:0]    rsp_type,
    input logic          out_valid,
    input logic [2:0]    out_type,
    input logic [CW-1:0] out_dst,
    input logic [CW-1:0] out_src,
    input logic          busy,
    input logic          tbl_we
);
    assert_inv_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == 3'd2) |-> (out_dst != out_src));

    assert_fwd_to_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_type == 3'd0 || out_type == 3'd1)) |-> (out_dst != out_src));

    assert_open_until_final_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(rsp_valid && (rsp_type == 2'd2 || rsp_type == 2'd3))) |=> busy);

    assert_final_only_when_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_type == 2'd2 || rsp_type == 2'd3)) |-> busy);

    assert_nack_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type == 2'd3) |-> !tbl_we);
endmodule

bind dir_sticky_home dir_sticky_home_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_type(rsp_type),
    .out_valid(out_valid), .out_type(out_type), .out_dst(out_dst), .out_src(out_src),
    .busy(ctrl_busy), .tbl_we(tbl_we)
);

// File: tb/dir_sticky_home_tb.sv
module dir_sticky_home_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 2;
    localparam int BW = 3;
    localparam int DW = 32;
    localparam int EW = 3 + CW + CW + BW + DW;
    localparam logic [2:0] GETS = 0, GETX = 1, PUTX = 2, WBTX = 3, WBSH = 4;
    localparam logic [1:0] CLEAN = 1, ACK = 2, NACK = 3;
    localparam logic [2:0] FWDS = 0, FWDX = 1, INV = 2, DATA = 3, WBACK = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_type = '0;
    logic [CW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_type = '0;
    logic [CW-1:0] rsp_src = '0;
    logic [BW-1:0] rsp_blk = '0;
    logic out_valid;
    logic [2:0] out_type;
    logic [CW-1:0] out_dst, out_src;
    logic [BW-1:0] out_blk;
    logic [DW-1:0] out_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string cur_tag = "R1";
    logic [EW-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_sticky_home u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_src(rsp_src), .rsp_blk(rsp_blk),
        .out_valid(out_valid), .out_type(out_type), .out_dst(out_dst),
        .out_src(out_src), .out_blk(out_blk), .out_data(out_data)
    );

    task automatic expect_msg(input logic [2:0] t, input int dst, input int src,
                              input int blk, input logic [DW-1:0] d, input string tag);
        exp_q.push_back({t, CW'(dst), CW'(src), BW'(blk), d});
        tag_q.push_back(tag);
    endtask

    task automatic send_req(input logic [2:0] t, input int src, input int blk,
                            input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_src = CW'(src); req_blk = BW'(blk); req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [1:0] t, input int src, input int blk);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_type = t; rsp_src = CW'(src); rsp_blk = BW'(blk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // Let outputs drain, then confirm every expected message appeared.
    task automatic drain(input string tag);
        repeat (8) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s missing messages: actual=%0d expected=0 pending", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Scoreboard monitor: every outgoing message is compared with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [EW-1:0] got;
            got = {out_type, out_dst, out_src, out_blk, out_data};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s unexpected message: actual=%h expected=none", cur_tag, got);
            end else begin
                logic [EW-1:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s message: actual=%h expected=%h", tg, got, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (out_valid !== 1'b0) begin
            fails++; $display("FAIL R1 out_valid: actual=%b expected=0", out_valid);
        end
        checks++;
        if (req_ready !== 1'b1) begin
            fails++; $display("FAIL R1 req_ready: actual=%b expected=1", req_ready);
        end

        // R2, R3: uncached read, then forwarded read and sharer
        cur_tag = "R2";
        expect_msg(DATA, 0, 0, 2, 0, "R2");
        send_req(GETS, 0, 2, 0); drain("R2"); send_rsp(ACK, 0, 2);
        cur_tag = "R3";
        expect_msg(FWDS, 0, 1, 2, 0, "R3");
        send_req(GETS, 1, 2, 0); drain("R3"); send_rsp(ACK, 1, 2);
        expect_msg(FWDS, 0, 2, 2, 0, "R3");
        send_req(GETS, 2, 2, 0); drain("R3"); send_rsp(ACK, 2, 2);
        // R4: GETX by sharer 1: forward to owner 0, INV only to 2
        cur_tag = "R4";
        expect_msg(FWDX, 0, 1, 2, 0, "R4");
        expect_msg(INV, 2, 1, 2, 0, "R4");
        send_req(GETX, 1, 2, 0); drain("R4"); send_rsp(ACK, 1, 2);
        expect_msg(FWDX, 1, 3, 2, 0, "R4");
        send_req(GETX, 3, 2, 0); drain("R4"); send_rsp(ACK, 3, 2);

        // R5, R6, R7, R8: sticky owner after transactional writeback
        cur_tag = "R6";
        expect_msg(DATA, 0, 0, 3, 0, "R2");
        send_req(GETX, 0, 3, 0); drain("R2"); send_rsp(ACK, 0, 3);
        cur_tag = "R5";
        expect_msg(WBACK, 0, 0, 3, 0, "R5");
        send_req(PUTX, 0, 3, 0); drain("R5");
        cur_tag = "R6";
        send_req(WBTX, 0, 3, 32'h0000_00A5); drain("R6");
        expect_msg(FWDS, 0, 1, 3, 0, "R6");
        send_req(GETS, 1, 3, 0); drain("R6");
        cur_tag = "R8";
        send_rsp(NACK, 1, 3); drain("R8");
        expect_msg(FWDS, 0, 1, 3, 0, "R8");
        send_req(GETS, 1, 3, 0); drain("R8");
        cur_tag = "R7";
        expect_msg(DATA, 1, 1, 3, 32'h0000_00A5, "R7");
        send_rsp(CLEAN, 0, 3); drain("R7"); send_rsp(ACK, 1, 3);
        expect_msg(FWDX, 1, 2, 3, 0, "R7");
        send_req(GETX, 2, 3, 0); drain("R7"); send_rsp(ACK, 2, 3);

        // R9: Owned/Exclusive writeback keeps the writer as sharer
        cur_tag = "R9";
        expect_msg(DATA, 3, 3, 4, 0, "R9");
        send_req(GETS, 3, 4, 0); drain("R9"); send_rsp(ACK, 3, 4);
        send_req(WBSH, 3, 4, 32'h0000_0077); drain("R9");
        expect_msg(DATA, 0, 0, 4, 32'h0000_0077, "R9");
        expect_msg(INV, 3, 0, 4, 0, "R9");
        send_req(GETX, 0, 4, 0); drain("R9"); send_rsp(ACK, 0, 4);

        // R10: silent Shared eviction by core 1; both sharers invalidated in order
        cur_tag = "R10";
        expect_msg(DATA, 0, 0, 5, 0, "R10");
        send_req(GETS, 0, 5, 0); drain("R10"); send_rsp(ACK, 0, 5);
        expect_msg(FWDS, 0, 1, 5, 0, "R10");
        send_req(GETS, 1, 5, 0); drain("R10"); send_rsp(ACK, 1, 5);
        send_req(WBSH, 0, 5, 32'h0000_0033); drain("R10");
        expect_msg(DATA, 2, 2, 5, 32'h0000_0033, "R10");
        expect_msg(INV, 0, 2, 5, 0, "R10");
        expect_msg(INV, 1, 2, 5, 0, "R10");
        send_req(GETX, 2, 5, 0); drain("R10"); send_rsp(ACK, 2, 5);

        // R11: requests wait behind an open transaction, served in order
        cur_tag = "R11";
        expect_msg(DATA, 0, 0, 6, 0, "R11");
        send_req(GETS, 0, 6, 0);
        send_req(GETS, 1, 6, 0);
        send_req(GETX, 2, 7, 0);
        drain("R11");
        expect_msg(FWDS, 0, 1, 6, 0, "R11");
        send_rsp(ACK, 0, 6); drain("R11");
        expect_msg(DATA, 2, 2, 7, 0, "R11");
        send_rsp(ACK, 1, 6); drain("R11");
        send_rsp(ACK, 2, 7);
        expect_msg(FWDS, 0, 3, 6, 0, "R3");
        send_req(GETS, 3, 6, 0); drain("R3"); send_rsp(ACK, 3, 6);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule